// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block keeps the three sticky interrupt flags of an 8-bit timer/counter and turns them into request lines. It watches the count value on each counter step and sets flags on matches against three compare values. Two of the flags track matches with compare values A and B. The third is the period flag. In normal mode it fires when the counter overflows. When either PWM enable is on, it fires instead when the count matches compare value C.

Software reads the flags through an 8-bit register port and clears them by writing ones. These clears take effect one synchronization cycle after the write. The interrupt controller clears a flag directly by pulsing that flag's acknowledge input. The register also shows three status bits that belong to a neighbouring timer. Each request line is the AND of the global enable, that flag's own enable and the flag itself.

Top module: `tmr_irq_flags`

## Requirements
- R1: On a cycle with `cnt_tick` high and `cnt_value == cmp_a`, flag A becomes one after that clock edge; it reads at register bit 6.
- R2: On a cycle with `cnt_tick` high and `cnt_value == cmp_b`, flag B becomes one after that clock edge; it reads at register bit 5.
- R3: With `pwm_a_en` and `pwm_b_en` both zero, the period flag (register bit 2) sets after a cycle with `cnt_tick` and `cnt_ovf` high; a match with `cmp_c` does not set it.
- R4: With either PWM enable one, the period flag sets after a cycle with `cnt_tick` high and `cnt_value == cmp_c`; `cnt_ovf` does not set it.
- R5: A high `ack_a`, `ack_b` or `ack_ovf` clears the matching flag at the same clock edge.
- R6: A register write with a one at bit 6, 5 or 2 clears that flag one cycle after the write edge; zeros written leave the flags unchanged.
- R7: `irq_a`, `irq_b` and `irq_ovf` are one exactly when `gie`, the flag's own enable and the flag are all one.
- R8: Register read data has bits 7 and 0 at zero, and bits 4, 3 and 1 equal `other_flags[2]`, `other_flags[1]` and `other_flags[0]`.
- R9: Reset clears all three flags.
- R10: When a set event and a clear (acknowledge or pending write clear) meet in the same cycle, the flag is one afterwards.
- R11: Without `cnt_tick`, a matching count value sets no flag, so a counter held at a match sets the flag once per count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Counter stepped this cycle; qualifies all set events |
| cnt_value | input | 8 | Current counter value |
| cnt_ovf | input | 1 | Counter wrapped from all-ones to zero |
| cmp_a | input | 8 | Compare value A |
| cmp_b | input | 8 | Compare value B |
| cmp_c | input | 8 | Compare value C (period in PWM modes) |
| pwm_a_en | input | 1 | PWM mode enable, channel A |
| pwm_b_en | input | 1 | PWM mode enable, channel B |
| gie | input | 1 | Global interrupt enable |
| ie_a | input | 1 | Enable for flag A request |
| ie_b | input | 1 | Enable for flag B request |
| ie_ovf | input | 1 | Enable for period flag request |
| ack_a | input | 1 | Vector acknowledge for flag A |
| ack_b | input | 1 | Vector acknowledge for flag B |
| ack_ovf | input | 1 | Vector acknowledge for period flag |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data, ones clear flags |
| other_flags | input | 3 | Neighbour-timer status bits shown at 4, 3, 1 |
| reg_rdata | output | 8 | Register read data |
| irq_a | output | 1 | Request for flag A |
| irq_b | output | 1 | Request for flag B |
| irq_ovf | output | 1 | Request for period flag |

## Verification
Set events and acknowledges show up in the flags, and so in the read data and requests, after the one clock edge that samples them. A write-one clear shows up only after the second edge: the flag still reads one after the write edge and zero after the next. Request gating and the pass-through bits are combinational from registered state and the enables. The bench drives inputs just after the falling edge and samples just after the next falling edge, so every result is read one edge after its stimulus. For write clears it checks at both edges.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int NFLAG = 3;
    // flag indices inside the flag vectors
    localparam int FI_A = 0;
    localparam int FI_B = 1;
    localparam int FI_O = 2;
    // bit positions in the 8-bit register
    localparam int RB_A  = 6;
    localparam int RB_B  = 5;
    localparam int RB_O  = 2;
    localparam int RB_X2 = 4;
    localparam int RB_X1 = 3;
    localparam int RB_X0 = 1;
    localparam int RW    = 8;

    typedef struct packed {
        logic flag;
    } flag_st_t;

    typedef struct packed {
        logic [NFLAG-1:0] pend;
    } clr_st_t;
endpackage

// File: rtl/tmr_evt_detect.sv
module tmr_evt_detect
    import tmr_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             tick_i,
    input  logic [W-1:0]     cnt_i,
    input  logic             ovf_i,
    input  logic [W-1:0]     cmp_a_i,
    input  logic [W-1:0]     cmp_b_i,
    input  logic [W-1:0]     cmp_c_i,
    input  logic             pwm_a_i,
    input  logic             pwm_b_i,
    output logic [NFLAG-1:0] set_o
);
    logic pwm_mode;
    logic hit_a, hit_b, hit_c;

    always_comb begin
        pwm_mode = pwm_a_i | pwm_b_i;
        hit_a    = (cnt_i == cmp_a_i);
        hit_b    = (cnt_i == cmp_b_i);
        hit_c    = (cnt_i == cmp_c_i);
        set_o        = '0;
        set_o[FI_A]  = tick_i & hit_a;
        set_o[FI_B]  = tick_i & hit_b;
        set_o[FI_O]  = tick_i & (pwm_mode ? hit_c : ovf_i);
    end
endmodule

// File: rtl/tmr_clr_sync.sv
module tmr_clr_sync
    import tmr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [NFLAG-1:0] ones_i,
    output logic [NFLAG-1:0] pend_o
);
    clr_st_t st_d, st_q;

    always_comb begin
        st_d.pend = wr_i ? ones_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_CLR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ones_i[FI_A]) |=> pend_o[FI_A]); // R6
    AST_CLR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> (pend_o == '0)); // R6
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell
    import tmr_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)               st_d.flag = 1'b1;
        else if (ack_i || clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !flag_o); // R5
    AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !ack_i && !clr_i) |=> flag_o); // R1
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tmr_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_tick,
    input  logic [W-1:0]  cnt_value,
    input  logic          cnt_ovf,
    input  logic [W-1:0]  cmp_a,
    input  logic [W-1:0]  cmp_b,
    input  logic [W-1:0]  cmp_c,
    input  logic          pwm_a_en,
    input  logic          pwm_b_en,
    input  logic          gie,
    input  logic          ie_a,
    input  logic          ie_b,
    input  logic          ie_ovf,
    input  logic          ack_a,
    input  logic          ack_b,
    input  logic          ack_ovf,
    input  logic          reg_wr,
    input  logic [RW-1:0] reg_wdata,
    input  logic [2:0]    other_flags,
    output logic [RW-1:0] reg_rdata,
    output logic          irq_a,
    output logic          irq_b,
    output logic          irq_ovf
);
    logic [NFLAG-1:0] set_evt, ack_vec, ie_vec, ones_vec, pend, flags, irq_vec;

    always_comb begin
        ack_vec        = '0;
        ack_vec[FI_A]  = ack_a;
        ack_vec[FI_B]  = ack_b;
        ack_vec[FI_O]  = ack_ovf;
        ie_vec         = '0;
        ie_vec[FI_A]   = ie_a;
        ie_vec[FI_B]   = ie_b;
        ie_vec[FI_O]   = ie_ovf;
        ones_vec       = '0;
        ones_vec[FI_A] = reg_wdata[RB_A];
        ones_vec[FI_B] = reg_wdata[RB_B];
        ones_vec[FI_O] = reg_wdata[RB_O];
    end

    tmr_evt_detect #(.W(W)) u_evt (
        .tick_i  (cnt_tick),
        .cnt_i   (cnt_value),
        .ovf_i   (cnt_ovf),
        .cmp_a_i (cmp_a),
        .cmp_b_i (cmp_b),
        .cmp_c_i (cmp_c),
        .pwm_a_i (pwm_a_en),
        .pwm_b_i (pwm_b_en),
        .set_o   (set_evt)
    );

    tmr_clr_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr),
        .ones_i (ones_vec),
        .pend_o (pend)
    );

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        tmr_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_evt[g]),
            .ack_i  (ack_vec[g]),
            .clr_i  (pend[g]),
            .flag_o (flags[g])
        );
        assign irq_vec[g] = gie & ie_vec[g] & flags[g];
    end

    always_comb begin
        reg_rdata        = '0;
        reg_rdata[RB_A]  = flags[FI_A];
        reg_rdata[RB_B]  = flags[FI_B];
        reg_rdata[RB_O]  = flags[FI_O];
        reg_rdata[RB_X2] = other_flags[2];
        reg_rdata[RB_X1] = other_flags[1];
        reg_rdata[RB_X0] = other_flags[0];
    end

    assign irq_a   = irq_vec[FI_A];
    assign irq_b   = irq_vec[FI_B];
    assign irq_ovf = irq_vec[FI_O];

    AST_CMP_A_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && cnt_value == cmp_a) |=> reg_rdata[RB_A]); // R1
    AST_CMP_B_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && cnt_value == cmp_b) |=> reg_rdata[RB_B]); // R2
    AST_NORMAL_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && cnt_ovf && !pwm_a_en && !pwm_b_en) |=> reg_rdata[RB_O]); // R3
    AST_PWM_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && (pwm_a_en || pwm_b_en) && cnt_value == cmp_c) |=> reg_rdata[RB_O]); // R4
    AST_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !reg_rdata[RB_A]) |=> !reg_rdata[RB_A]); // R11
    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a || irq_b || irq_ovf) |-> gie); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata[RB_A] == 1'b0 && reg_rdata[RB_B] == 1'b0)); // R9
endmodule

// File: tb/test_tmr_irq_flags.sv
module test_tmr_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cnt_tick, cnt_ovf;
    logic [7:0] cnt_value, cmp_a, cmp_b, cmp_c;
    logic       pwm_a_en, pwm_b_en, gie, ie_a, ie_b, ie_ovf;
    logic       ack_a, ack_b, ack_ovf, reg_wr;
    logic [7:0] reg_wdata;
    logic [2:0] other_flags;
    logic [7:0] reg_rdata;
    logic       irq_a, irq_b, irq_ovf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    tmr_irq_flags i_tmr_irq_flags (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_value(cnt_value),
        .cnt_ovf(cnt_ovf), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
        .pwm_a_en(pwm_a_en), .pwm_b_en(pwm_b_en), .gie(gie), .ie_a(ie_a),
        .ie_b(ie_b), .ie_ovf(ie_ovf), .ack_a(ack_a), .ack_b(ack_b),
        .ack_ovf(ack_ovf), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .other_flags(other_flags), .reg_rdata(reg_rdata), .irq_a(irq_a),
        .irq_b(irq_b), .irq_ovf(irq_ovf)
    );

    // {tick, ovf, pwm_a, pwm_b, cnt[7:0], ack a/b/o, expected flags a/b/o}
    // compare values: A=0x10, B=0x20, C=0x30
    localparam logic [17:0] VEC [12] = '{
        {1'b1, 1'b0, 2'b00, 8'h10, 3'b000, 3'b100},  // R1
        {1'b1, 1'b0, 2'b00, 8'h20, 3'b100, 3'b010},  // R2, R5
        {1'b0, 1'b0, 2'b01, 8'h30, 3'b010, 3'b000},  // R11, R5
        {1'b1, 1'b0, 2'b01, 8'h30, 3'b000, 3'b001},  // R4
        {1'b1, 1'b0, 2'b00, 8'h05, 3'b001, 3'b000},  // R5
        {1'b1, 1'b0, 2'b00, 8'h30, 3'b000, 3'b000},  // R3 C ignored
        {1'b1, 1'b1, 2'b00, 8'h00, 3'b000, 3'b001},  // R3
        {1'b1, 1'b1, 2'b10, 8'h00, 3'b001, 3'b000},  // R4 overflow ignored
        {1'b1, 1'b0, 2'b00, 8'h10, 3'b000, 3'b100},  // R1
        {1'b1, 1'b0, 2'b00, 8'h10, 3'b100, 3'b100},  // R10
        {1'b0, 1'b0, 2'b00, 8'h10, 3'b100, 3'b000},  // R5
        {1'b0, 1'b0, 2'b00, 8'h10, 3'b000, 3'b000}   // R11
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        #0.5;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] flg();
        return {reg_rdata[6], reg_rdata[5], reg_rdata[2]};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; cnt_tick = 0; cnt_ovf = 0; cnt_value = 0;
        cmp_a = 8'h10; cmp_b = 8'h20; cmp_c = 8'h30;
        pwm_a_en = 0; pwm_b_en = 0; gie = 1; ie_a = 1; ie_b = 1; ie_ovf = 1;
        ack_a = 0; ack_b = 0; ack_ovf = 0; reg_wr = 0; reg_wdata = 0;
        other_flags = 0;
        repeat (3) cyc();
        chk("R9 reset rdata", reg_rdata, 8'h00);
        chk("R9 reset irq", {5'b0, irq_a, irq_b, irq_ovf}, 8'h00);
        rst_n = 1;

        for (int i = 0; i < 12; i++) begin
            {cnt_tick, cnt_ovf, pwm_a_en, pwm_b_en, cnt_value,
             ack_a, ack_b, ack_ovf} = VEC[i][17:3];
            cyc();
            chk($sformatf("R1-table vec%0d flags", i), {5'b0, flg()}, {5'b0, VEC[i][2:0]});
        end
        cnt_tick = 0; cnt_ovf = 0; pwm_a_en = 0; pwm_b_en = 0;
        ack_a = 0; ack_b = 0; ack_ovf = 0;

        // R8 reserved and pass-through bits
        other_flags = 3'b101;
        cyc();
        chk("R8 passthrough 101", reg_rdata, 8'h12);
        other_flags = 3'b010;
        cyc();
        chk("R8 passthrough 010", reg_rdata, 8'h08);
        other_flags = 3'b000;

        // R6 zero write has no effect, one write clears one cycle late
        cnt_tick = 1; cnt_value = 8'h10;
        cyc();
        cnt_tick = 0;
        chk("R1 set before clear", reg_rdata, 8'h40);
        reg_wr = 1; reg_wdata = 8'h00;
        cyc();
        reg_wr = 0;
        cyc();
        chk("R6 zero write ignored", reg_rdata, 8'h40);
        reg_wr = 1; reg_wdata = 8'h40;
        cyc();
        reg_wr = 0;
        chk("R6 flag still set at write edge", reg_rdata, 8'h40);
        cyc();
        chk("R6 flag cleared one cycle later", reg_rdata, 8'h00);

        // R10 pending clear meets a set
        cnt_tick = 1; cnt_value = 8'h10;
        cyc();
        cnt_tick = 0;
        reg_wr = 1; reg_wdata = 8'h40;
        cyc();
        reg_wr = 0; cnt_tick = 1; cnt_value = 8'h10;
        cyc();
        cnt_tick = 0;
        chk("R10 set beats pending clear", reg_rdata, 8'h40);
        cyc();
        chk("R10 flag stays after clear", reg_rdata, 8'h40);

        // R7 request gating, flag A set
        ie_a = 0; #0.5;
        chk("R7 irq_a own enable off", {7'b0, irq_a}, 8'h00);
        ie_a = 1; #0.5;
        chk("R7 irq_a all on", {7'b0, irq_a}, 8'h01);
        gie = 0; #0.5;
        chk("R7 irq_a global off", {7'b0, irq_a}, 8'h00);
        gie = 1;
        chk("R7 irq_b flag clear", {7'b0, irq_b}, 8'h00);
        pwm_a_en = 1; cnt_tick = 1; cnt_value = 8'h30;
        cyc();
        cnt_tick = 0;
        chk("R4 period flag in pwm", reg_rdata, 8'h44);
        chk("R7 irq_ovf on", {7'b0, irq_ovf}, 8'h01);
        ie_ovf = 0; #0.5;
        chk("R7 irq_ovf enable off", {7'b0, irq_ovf}, 8'h00);

        // R9 reset mid-run
        rst_n = 0;
        cyc();
        chk("R9 reset clears flags", reg_rdata, 8'h00);
        rst_n = 1;
        cyc();
        finish_run();
    end
endmodule